// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets a clocked system read and write an external asynchronous static RAM of 16-bit words, where each 8-bit half of a word has its own active-low lane strobe. The host side is a single request port. It carries a read/write flag, a word address, write data and a per-lane mask, and the block answers with a one-cycle response pulse that carries the read data. The memory side drives active-low chip, write and output enables, one strobe per byte lane, the address, and a shared bidirectional data bus. An output shows when the controller itself drives that bus.

Each access runs a fixed cycle sequence. The address and lane strobes are set up one cycle ahead of the active strobe. The write or read strobe is then held for a parameterised number of cycles, long enough to cover the memory's 10 ns access time. For a write, one hold cycle follows. The controller drives the data bus only while a write is in progress, and it enforces dead cycles between its own driving and the memory's. Chip enable is high whenever no access is under way, so the memory can power itself down.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip, write and output enables and both lane strobes are high, the bus is not driven (`mem_dq_oe` low), `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only when the block is idle, and a request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Each accepted request gives exactly one `rsp_valid` pulse. That pulse comes WAIT_CYC+3 cycles after acceptance for a write and WAIT_CYC+2 cycles after for a read, provided the mask is nonzero. A write response carries zero data.
- R3: In a write, chip enable stays low throughout and write enable is low for exactly WAIT_CYC cycles. Mask bit 0 selects data bits 7..0 through lane strobe 0, and mask bit 1 selects bits 15..8 through lane strobe 1. A lane whose mask bit is clear keeps its stored value.
- R4: In a read, output enable is low for exactly WAIT_CYC cycles while write enable is high and chip enable is low. The address stays stable through that window, and the bus is sampled at its last edge.
- R5: The controller drives the bus only during writes. It never drives the bus while output enable is low. It releases the bus at least one cycle before output enable falls, and output enable stays high for at least one cycle after the release.
- R6: Address, write data and lane strobes are valid one cycle before write enable falls and remain unchanged for one cycle after it rises. The bus is still driven and chip enable is still low during that hold cycle.
- R7: Chip enable is high whenever the block is idle.
- R8: A request with an all-zero mask produces no memory strobe. It responds one cycle after acceptance with zero data and leaves memory contents unchanged.
- R9: In read data, a lane whose mask bit is clear is returned as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | 2 | Lane strobes, active low, bit 0 = low byte |
| mem_addr | output | 15 | Memory address |
| mem_dq | inout | 16 | Shared data bus |
| mem_dq_oe | output | 1 | High while the controller drives mem_dq |

## Verification
The bench builds the controller with an 8-bit address and a strobe width of two cycles, which fits an 8 ns clock against a 10 ns access time. The small address space lets every word of the memory model be written and read back in full, then rewritten one lane at a time in alternating order and read back again as a full word. A two-cycle window is short enough that latencies and strobe widths are counted exactly on every access. Lane-masked reads, zero-mask requests and a bus contention monitor cover the turnaround and lane corner cases.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSET   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RSET   = 3'd4,
    ST_RWAIT  = 3'd5,
    ST_DONE   = 3'd6
  } ctrl_state_t;

  function automatic logic is_write_phase(ctrl_state_t s);
    return (s == ST_WSET) || (s == ST_WPULSE) || (s == ST_WHOLD);
  endfunction

  function automatic logic is_active_phase(ctrl_state_t s);
    return is_write_phase(s) || (s == ST_RSET) || (s == ST_RWAIT);
  endfunction
endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int WAIT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R3 / R4: the strobe window counter never exceeds its load value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD_VAL);
  // R4: after a load the counter holds the full window
  p_load_value_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == LOAD_VAL));
endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              clear,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata
);
  localparam int LW = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (capture) begin
        lane_q <= lane_en[g] ? bus_in[g*LW +: LW] : '0;
      end else if (clear) begin
        lane_q <= '0;
      end
    end
    assign rdata[g*LW +: LW] = lane_q;

    // R9: a lane captured while disabled reads back as zero
    p_lane_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (capture && !lane_en[g]) |=> (lane_q == '0));
  end
endmodule

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              req_ready,
  output logic              timer_load,
  input  logic              timer_expired,
  output logic              cap_en,
  output logic              clr_en,
  output logic [LANES-1:0]  lane_en,
  output logic              rsp_valid,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_dq_oe
);
  ctrl_state_t state_q, state_d;
  logic              accept;
  logic              mask_none;
  logic [LANES-1:0]  mask_q, mask_next;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mask_none = (req_mask == '0);
  assign mask_next = accept ? req_mask : mask_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (mask_none)      state_d = ST_DONE;
          else if (req_write) state_d = ST_WSET;
          else                state_d = ST_RSET;
        end
      end
      ST_WSET:   state_d = ST_WPULSE;
      ST_WPULSE: if (timer_expired) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_DONE;
      ST_RSET:   state_d = ST_RWAIT;
      ST_RWAIT:  if (timer_expired) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign timer_load = (state_q == ST_WSET) || (state_q == ST_RSET);
  assign cap_en     = (state_q == ST_RWAIT) && timer_expired;
  assign clr_en     = accept && (req_write || mask_none);
  assign lane_en    = mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (accept) begin
      mask_q    <= req_mask;
      mem_addr  <= req_addr;
      mem_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_lane_n <= '1;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
    end else begin
      mem_ce_n   <= !is_active_phase(state_d);
      mem_we_n   <= (state_d != ST_WPULSE);
      mem_oe_n   <= (state_d != ST_RWAIT);
      mem_lane_n <= is_active_phase(state_d) ? ~mask_next : '1;
      mem_dq_oe  <= is_write_phase(state_d);
      rsp_valid  <= (state_d == ST_DONE);
    end
  end

  // R3: write strobe only inside a chip-enabled access
  p_we_in_ce_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);
  // R4: read strobe only with write enable high and chip selected
  p_read_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));
  // R4: address held while output enable is low
  p_read_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n && !$fell(mem_oe_n)) |-> $stable(mem_addr));
  // R5: never drive while the memory may drive
  p_no_clash_r5: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);
  // R5: bus released a cycle before output enable falls
  p_release_first_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
  // R5: output enable stays high one cycle past the release
  p_oe_gap_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_dq_oe) |=> mem_oe_n);
  // R6: setup cycle before write enable falls
  p_wr_setup_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && !$past(mem_ce_n) &&
                         $stable(mem_addr) && $stable(mem_lane_n) && $stable(mem_wdata)));
  // R6: hold cycle after write enable rises
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n &&
                         $stable(mem_addr) && $stable(mem_lane_n) && $stable(mem_wdata)));
  // R7: chip deselected when idle
  p_idle_ce_r7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_ce_n);
  // R8: empty mask completes at once without a strobe
  p_zero_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && mask_none) |=> (rsp_valid && mem_ce_n && mem_we_n && mem_oe_n));
  // R2: response pulse lasts a single cycle
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 16,
  parameter int WAIT_CYC = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W/8-1:0]     req_mask,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [DATA_W/8-1:0]     mem_lane_n,
  output logic [ADDR_W-1:0]       mem_addr,
  inout  wire  [DATA_W-1:0]       mem_dq,
  output logic                    mem_dq_oe
);
  localparam int LANES = DATA_W / 8;

  logic              timer_load, timer_expired;
  logic              cap_en, clr_en;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] wdata_out;

  sram_lane_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_mask      (req_mask),
    .req_ready     (req_ready),
    .timer_load    (timer_load),
    .timer_expired (timer_expired),
    .cap_en        (cap_en),
    .clr_en        (clr_en),
    .lane_en       (lane_en),
    .rsp_valid     (rsp_valid),
    .mem_ce_n      (mem_ce_n),
    .mem_we_n      (mem_we_n),
    .mem_oe_n      (mem_oe_n),
    .mem_lane_n    (mem_lane_n),
    .mem_addr      (mem_addr),
    .mem_wdata     (wdata_out),
    .mem_dq_oe     (mem_dq_oe)
  );

  sram_wait_timer #(
    .WAIT_CYC (WAIT_CYC)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (timer_load),
    .expired (timer_expired)
  );

  sram_lane_capture #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_capture (
    .clk     (clk),
    .rst     (rst),
    .capture (cap_en),
    .clear   (clr_en),
    .lane_en (lane_en),
    .bus_in  (mem_dq),
    .rdata   (rsp_rdata)
  );

  assign mem_dq = mem_dq_oe ? wdata_out : {DATA_W{1'bz}};
endmodule

// File: tb/sram_model.sv
module sram_model #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [DW/8-1:0]   lane_n,
  input  logic [AW-1:0]     addr,
  inout  wire  [DW-1:0]     dq,
  output logic              drive_any
);
  localparam int NL = DW / 8;

  logic [DW-1:0] mem [2**AW];
  logic          rd_en;

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = '0;
  end

  assign rd_en     = !ce_n && !oe_n && we_n;
  assign drive_any = rd_en && (lane_n != '1);

  for (genvar g = 0; g < NL; g++) begin : g_out
    assign dq[g*8 +: 8] = (rd_en && !lane_n[g]) ? mem[addr][g*8 +: 8] : 8'hzz;
  end

  always @(posedge we_n) begin
    if (ce_n == 1'b0) begin
      for (int i = 0; i < NL; i++) begin
        if (lane_n[i] == 1'b0) mem[addr][i*8 +: 8] = dq[i*8 +: 8];
      end
    end
  end
endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int W  = 2;
  localparam int NW = 2**AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic          req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata;
  logic [1:0]    mem_lane_n;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;
  logic          model_drive;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] refm [NW];

  always #4 clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(W)) i_sram_lane_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .mem_dq_oe(mem_dq_oe));

  sram_model #(.AW(AW), .DW(DW)) u_mem (
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .lane_n(mem_lane_n),
    .addr(mem_addr), .dq(mem_dq), .drive_any(model_drive));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return 16'(a * 40503 + k * 7919) ^ 16'h5A3C;
  endfunction

  // strobe-width and bus monitors
  int we_run = 0, oe_run = 0;
  logic [AW-1:0] oe_addr;
  logic mon_on = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin
        chk(we_run == W, "R3 write strobe width", we_run, W);
        we_run = 0;
      end
      if (!mem_oe_n) begin
        if (oe_run == 0) oe_addr = mem_addr;
        else chk(mem_addr == oe_addr, "R4 address stable in read", int'(mem_addr), int'(oe_addr));
        oe_run++;
      end else if (oe_run != 0) begin
        chk(oe_run == W, "R4 read strobe width", oe_run, W);
        oe_run = 0;
      end
      if (mem_dq_oe && model_drive) chk(1'b0, "R5 bus contention", 1, 0);
    end
  end

  task automatic xfer(input logic wr, input int a, input logic [DW-1:0] d,
                      input logic [1:0] m, output logic [DW-1:0] rd, output int lat);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    chk(mem_ce_n == 1'b1, "R7 ce high at completion", mem_ce_n, 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 single response pulse", rsp_valid, 0);
  endtask

  task automatic wr_word(input int a, input logic [DW-1:0] d, input logic [1:0] m);
    logic [DW-1:0] rd; int lat;
    xfer(1'b1, a, d, m, rd, lat);
    chk(lat == W + 3, "R2 write latency", lat, W + 3);
    chk(rd == '0, "R2 write response data", int'(rd), 0);
    for (int i = 0; i < 2; i++) if (m[i]) refm[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic rd_word(input int a, input logic [1:0] m, input string tag);
    logic [DW-1:0] rd, exp; int lat;
    xfer(1'b0, a, '0, m, rd, lat);
    exp = '0;
    for (int i = 0; i < 2; i++) if (m[i]) exp[i*8 +: 8] = refm[a][i*8 +: 8];
    chk(lat == W + 2, "R2 read latency", lat, W + 2);
    chk(rd == exp, tag, int'(rd), int'(exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd; int lat;
    for (int i = 0; i < NW; i++) refm[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 enables high", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(mem_lane_n == 2'b11, "R1 lane strobes high", mem_lane_n, 3);
    chk(!mem_dq_oe && req_ready && !rsp_valid, "R1 bus idle and ready",
        {mem_dq_oe, req_ready, rsp_valid}, 2);
    mon_on = 1'b1;

    // R3 full-word write sweep, then full read-back sweep (R4)
    for (int a = 0; a < NW; a++) wr_word(a, pat(a, 1), 2'b11);
    for (int a = 0; a < NW; a++) rd_word(a, 2'b11, "R4 full read after full write");

    // R3 single-lane rewrites, alternating lane, checked as full words
    for (int a = 0; a < NW; a++) wr_word(a, pat(a, 2), (a % 2 == 0) ? 2'b01 : 2'b10);
    for (int a = 0; a < NW; a++) rd_word(a, 2'b11, "R3 partial lane write");

    // R9 lane-masked reads return zero in the disabled lane
    for (int a = 0; a < NW; a += 3) begin
      rd_word(a, 2'b01, "R9 low lane only");
      rd_word(a, 2'b10, "R9 high lane only");
    end

    // R8 zero-mask write and read
    for (int a = 0; a < NW; a += 17) begin
      xfer(1'b1, a, ~refm[a], 2'b00, rd, lat);
      chk(lat == 1, "R8 zero-mask write latency", lat, 1);
      chk(rd == '0, "R8 zero-mask write data", int'(rd), 0);
      xfer(1'b0, a, '0, 2'b00, rd, lat);
      chk(lat == 1, "R8 zero-mask read latency", lat, 1);
      chk(rd == '0, "R8 zero-mask read data", int'(rd), 0);
      rd_word(a, 2'b11, "R8 memory unchanged");
    end

    // R5 write immediately followed by read of the same word
    for (int a = 0; a < 8; a++) begin
      wr_word(a, pat(a, 3), 2'b11);
      rd_word(a, 2'b11, "R5 read after write turnaround");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule